// File: doc/BRIEF.md
# Multi-size ALU condition-code register

This block holds an 8-bit condition-code register and the arithmetic that feeds it. The arithmetic works on byte, word and long operands. For each instruction it takes two operands, an operation code and a size code. It returns the result in the same cycle and loads the half-carry, negative, zero, overflow and carry flags into the register at the next clock edge. Compare updates the flags but marks the result as not to be written back. The extend variants fold the current carry flag into the calculation.

Software can also act on the register directly. It can load a whole byte into it, or combine it by AND, OR or XOR with an immediate byte. The register value is always visible on an output. Exception entry forces the interrupt-mask bit to 1. That bit is also brought out as the interrupt-mask output for the interrupt controller. The controller lets non-maskable requests through whatever the mask says.

Top module: `alu_ccr`

## Requirements
- R1: After reset `ccr_o` is 8'h80 and `irq_mask_o` is 1. Bit 7 resets to 1, and every other bit resets to 0.
- R2: The bit layout from bit 7 down to bit 0 is I, UI, H, U, N, Z, V, C. `irq_mask_o` always equals bit 7 (I).
- R3: `ccr_op_i` = 1 (load) writes `ccr_imm_i` into the register at the next rising edge. `ccr_o` shows the register contents at all times.
- R4: `ccr_op_i` = 2, 3 and 4 replace the register at the next edge with its bitwise AND, OR and XOR with `ccr_imm_i`.
- R5: When `exc_entry_i` is high, bit 7 is 1 after the next edge, even if a register operation writes a 0 there in the same cycle. The other bits follow the register operation.
- R6: `arith_op_i` selects add 0, add-with-extend 1, subtract 2, subtract-with-extend 3, compare 4, negate 5. Subtract computes a − b, and negate computes 0 − a. `size_i` selects byte 0, word 1, long 2. `result_o` is combinational and is zero-extended above the active size.
- R7: H is the carry or borrow out of bit 3 for byte, bit 11 for word and bit 27 for long.
- R8: N is the top bit of the result at the active size, and Z is 1 exactly when the result at that size is zero.
- R9: C is the carry or borrow out of the top bit at the active size. V is set on two's-complement signed overflow.
- R10: Add-with-extend adds the C flag as carry-in. Subtract-with-extend subtracts it as borrow-in.
- R11: Compare sets the flags as subtract does. `result_we_o` is 0 for compare and 1 for the other operations while `arith_valid_i` is high.
- R12: An arithmetic update leaves UI and U unchanged. If a register operation occurs in the same cycle, the register operation wins and the arithmetic flags are ignored. With no operation in a cycle, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arith_valid_i | input | 1 | Arithmetic operation present this cycle |
| arith_op_i | input | 3 | Arithmetic operation code |
| size_i | input | 2 | Operand size code |
| src_a_i | input | 32 | First operand (minuend, negate source) |
| src_b_i | input | 32 | Second operand |
| result_o | output | 32 | Arithmetic result, zero-extended |
| result_we_o | output | 1 | Result should be written back |
| ccr_op_i | input | 3 | Register operation: none, load, and, or, xor |
| ccr_imm_i | input | 8 | Immediate byte for register operations |
| exc_entry_i | input | 1 | Exception-handling sequence starts |
| ccr_o | output | 8 | Register contents |
| irq_mask_o | output | 1 | Interrupt mask (bit I) |

## Verification
Two pairs of functions can occur in the same cycle. Exception entry can coincide with a software register write, and an arithmetic flag update can coincide with a register operation. The bench provokes each clash directly. A load of 8'h00 is issued together with exception entry, and the result must read 8'h80. A load is issued together with an add that would set Z and C, and only the loaded byte may appear afterwards.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDX = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBX = 3'd3,
    OP_CMP  = 3'd4,
    OP_NEG  = 3'd5
  } arith_op_e;

  typedef enum logic [2:0] {
    REG_NONE = 3'd0,
    REG_LOAD = 3'd1,
    REG_AND  = 3'd2,
    REG_OR   = 3'd3,
    REG_XOR  = 3'd4
  } reg_op_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam int BIT_I  = 7;
  localparam int BIT_UI = 6;
  localparam int BIT_H  = 5;
  localparam int BIT_U  = 4;
  localparam int BIT_N  = 3;
  localparam int BIT_Z  = 2;
  localparam int BIT_V  = 1;
  localparam int BIT_C  = 0;
  localparam logic [7:0] CCR_RESET = 8'h80;
endpackage

// File: rtl/ccr_arith_slice.sv
module ccr_arith_slice
  import ccr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] r_o,
  output flags_t       fl_o
);
  localparam int HB = W - 4;  // half-carry taken out of bit HB-1

  logic [W:0]  full;
  logic [HB:0] low;

  always_comb begin
    if (sub_i) begin
      full = {1'b0, x_i} - {1'b0, y_i} - {{W{1'b0}}, cin_i};
      low  = {1'b0, x_i[HB-1:0]} - {1'b0, y_i[HB-1:0]} - {{HB{1'b0}}, cin_i};
    end else begin
      full = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
      low  = {1'b0, x_i[HB-1:0]} + {1'b0, y_i[HB-1:0]} + {{HB{1'b0}}, cin_i};
    end
  end

  assign r_o  = full[W-1:0];
  assign fl_o.h = low[HB];
  assign fl_o.c = full[W];
  assign fl_o.n = full[W-1];
  assign fl_o.z = (full[W-1:0] == '0);
  assign fl_o.v = sub_i ? ((x_i[W-1] ^ y_i[W-1]) & (full[W-1] ^ x_i[W-1]))
                        : (~(x_i[W-1] ^ y_i[W-1]) & (full[W-1] ^ x_i[W-1]));
endmodule

// File: rtl/ccr_reg.sv
module ccr_reg
  import ccr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arith_upd_i,
  input  flags_t     arith_fl_i,
  input  logic [2:0] reg_op_i,
  input  logic [7:0] imm_i,
  input  logic       exc_entry_i,
  output logic [7:0] ccr_o
);
  logic [7:0] ccr_q, ccr_d;
  reg_op_e    rop;

  assign rop = reg_op_e'(reg_op_i);

  always_comb begin
    ccr_d = ccr_q;
    unique case (rop)
      REG_LOAD: ccr_d = imm_i;
      REG_AND:  ccr_d = ccr_q & imm_i;
      REG_OR:   ccr_d = ccr_q | imm_i;
      REG_XOR:  ccr_d = ccr_q ^ imm_i;
      default: begin
        if (arith_upd_i) begin
          ccr_d[BIT_H] = arith_fl_i.h;
          ccr_d[BIT_N] = arith_fl_i.n;
          ccr_d[BIT_Z] = arith_fl_i.z;
          ccr_d[BIT_V] = arith_fl_i.v;
          ccr_d[BIT_C] = arith_fl_i.c;
        end
      end
    endcase
    if (exc_entry_i) ccr_d[BIT_I] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ccr_q <= CCR_RESET;
    else         ccr_q <= ccr_d;
  end

  assign ccr_o = ccr_q;

  assert_exc_sets_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_entry_i |=> ccr_q[BIT_I]);

  assert_load_takes_imm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rop == REG_LOAD && !exc_entry_i) |=> ccr_q == $past(imm_i));

  assert_and_combines_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rop == REG_AND && !exc_entry_i) |=> ccr_q == ($past(ccr_q) & $past(imm_i)));

  assert_user_bits_kept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rop == REG_NONE) |=> ($stable(ccr_q[BIT_UI]) && $stable(ccr_q[BIT_U])));

  assert_idle_holds_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rop == REG_NONE && !arith_upd_i && !exc_entry_i) |=> $stable(ccr_q));
endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
  import ccr_pkg::*;
#(
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   arith_valid_i,
  input  logic [2:0]                             arith_op_i,
  input  logic [1:0]                             size_i,
  input  logic [(BASE_W<<(NUM_SIZES-1))-1:0]     src_a_i,
  input  logic [(BASE_W<<(NUM_SIZES-1))-1:0]     src_b_i,
  output logic [(BASE_W<<(NUM_SIZES-1))-1:0]     result_o,
  output logic                                   result_we_o,
  input  logic [2:0]                             ccr_op_i,
  input  logic [7:0]                             ccr_imm_i,
  input  logic                                   exc_entry_i,
  output logic [7:0]                             ccr_o,
  output logic                                   irq_mask_o
);
  localparam int DATA_W = BASE_W << (NUM_SIZES - 1);

  arith_op_e         op;
  logic              is_sub, is_neg, use_ext, op_legal;
  logic [DATA_W-1:0] x_op, y_op;
  logic              cur_c;
  int unsigned       sel;

  logic [DATA_W-1:0] res_all [NUM_SIZES];
  flags_t            fl_all  [NUM_SIZES];
  flags_t            fl_sel;
  logic [7:0]        ccr_val;

  assign op       = arith_op_e'(arith_op_i);
  assign is_neg   = (op == OP_NEG);
  assign is_sub   = (op == OP_SUB) || (op == OP_SUBX) || (op == OP_CMP) || is_neg;
  assign use_ext  = (op == OP_ADDX) || (op == OP_SUBX);
  assign op_legal = (arith_op_i <= 3'd5);
  assign x_op     = is_neg ? '0 : src_a_i;
  assign y_op     = is_neg ? src_a_i : src_b_i;
  assign cur_c    = ccr_val[BIT_C];
  assign sel      = (int'(size_i) >= NUM_SIZES) ? NUM_SIZES - 1 : int'(size_i);

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int SW = BASE_W << k;
    logic [SW-1:0] r_k;
    ccr_arith_slice #(.W(SW)) i_slice (
      .x_i  (x_op[SW-1:0]),
      .y_i  (y_op[SW-1:0]),
      .cin_i(use_ext & cur_c),
      .sub_i(is_sub),
      .r_o  (r_k),
      .fl_o (fl_all[k])
    );
    assign res_all[k] = DATA_W'(r_k);
  end

  assign result_o    = res_all[sel];
  assign fl_sel      = fl_all[sel];
  assign result_we_o = arith_valid_i && op_legal && (op != OP_CMP);

  ccr_reg i_ccr_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arith_upd_i(arith_valid_i && op_legal),
    .arith_fl_i (fl_sel),
    .reg_op_i   (ccr_op_i),
    .imm_i      (ccr_imm_i),
    .exc_entry_i(exc_entry_i),
    .ccr_o      (ccr_val)
  );

  assign ccr_o      = ccr_val;
  assign irq_mask_o = ccr_val[BIT_I];

  assert_cmp_no_writeback_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arith_valid_i && op == OP_CMP) |-> !result_we_o);

  assert_zero_matches_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arith_valid_i && op_legal && ccr_op_i == 3'd0) |=> (ccr_o[BIT_Z] == ($past(result_o) == '0)));
endmodule

// File: tb/test_alu_ccr.sv
`timescale 1ns/1ps
module test_alu_ccr;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        arith_valid_i = 0;
  logic [2:0]  arith_op_i = 0;
  logic [1:0]  size_i = 0;
  logic [31:0] src_a_i = 0, src_b_i = 0;
  logic [31:0] result_o;
  logic        result_we_o;
  logic [2:0]  ccr_op_i = 0;
  logic [7:0]  ccr_imm_i = 0;
  logic        exc_entry_i = 0;
  logic [7:0]  ccr_o;
  logic        irq_mask_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  alu_ccr i_alu_ccr (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Apply one arithmetic op, check result and write-enable combinationally, flags after the edge
  task automatic arith(string req, logic [2:0] op, logic [1:0] sz, logic [31:0] a, logic [31:0] b,
                       logic [31:0] exp_r, logic exp_we, logic [7:0] exp_ccr);
    @(negedge clk_i);
    arith_valid_i = 1; arith_op_i = op; size_i = sz; src_a_i = a; src_b_i = b;
    #1;
    chk({req, " result"}, result_o, exp_r);
    chk({req, " write-enable"}, 32'(result_we_o), 32'(exp_we));
    @(posedge clk_i); #1;
    arith_valid_i = 0;
    chk({req, " flags"}, 32'(ccr_o), 32'(exp_ccr));
  endtask

  task automatic regop(string req, logic [2:0] rop, logic [7:0] imm, logic exc, logic [7:0] exp_ccr);
    @(negedge clk_i);
    ccr_op_i = rop; ccr_imm_i = imm; exc_entry_i = exc;
    @(posedge clk_i); #1;
    ccr_op_i = 0; exc_entry_i = 0;
    chk({req, " ccr"}, 32'(ccr_o), 32'(exp_ccr));
    chk({req, " irq mask (R2)"}, 32'(irq_mask_o), 32'(exp_ccr[7]));
  endtask

  task automatic t_reset();
    chk("R1 reset ccr", 32'(ccr_o), 32'h80);
    chk("R1 reset irq mask", 32'(irq_mask_o), 32'h1);
  endtask

  task automatic t_byte_add();
    arith("R7 byte half-carry", 3'd0, 2'd0, 32'h0F, 32'h01, 32'h10, 1, 8'hA0);
    arith("R9 byte signed overflow", 3'd0, 2'd0, 32'h7F, 32'h01, 32'h80, 1, 8'hAA);
    arith("R8 R9 byte zero and carry", 3'd0, 2'd0, 32'hFF, 32'h01, 32'h00, 1, 8'hA5);
    arith("R10 byte add-extend", 3'd1, 2'd0, 32'h10, 32'h20, 32'h31, 1, 8'h80);
  endtask

  task automatic t_byte_sub();
    arith("R7 byte sub borrow bit3", 3'd2, 2'd0, 32'h10, 32'h01, 32'h0F, 1, 8'hA0);
    arith("R9 byte sub borrow out", 3'd2, 2'd0, 32'h00, 32'h01, 32'hFF, 1, 8'hA9);
    arith("R10 byte sub-extend", 3'd3, 2'd0, 32'h05, 32'h02, 32'h02, 1, 8'h80);
  endtask

  task automatic t_wide();
    arith("R6 R7 word half-carry bit11", 3'd0, 2'd1, 32'hFFFF_0800, 32'h0000_0800, 32'h1000, 1, 8'hA0);
    arith("R9 word overflow", 3'd0, 2'd1, 32'h7FFF, 32'h0001, 32'h8000, 1, 8'hAA);
    arith("R7 word sub borrow bit11", 3'd2, 2'd1, 32'h1000, 32'h0001, 32'h0FFF, 1, 8'hA0);
    arith("R7 long half-carry bit27", 3'd0, 2'd2, 32'h0800_0000, 32'h0800_0000, 32'h1000_0000, 1, 8'hA0);
    arith("R8 long wrap to zero", 3'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 32'h0, 1, 8'hA5);
  endtask

  task automatic t_cmp_neg();
    arith("R11 compare equal", 3'd4, 2'd0, 32'h05, 32'h05, 32'h00, 0, 8'h84);
    arith("R6 negate one", 3'd5, 2'd0, 32'h01, 32'h00, 32'hFF, 1, 8'hA9);
    arith("R9 negate most negative", 3'd5, 2'd0, 32'h80, 32'h00, 32'h80, 1, 8'h8B);
  endtask

  task automatic t_regops();
    regop("R3 load", 3'd1, 8'h5A, 0, 8'h5A);
    regop("R4 and", 3'd2, 8'h0F, 0, 8'h0A);
    regop("R4 or", 3'd3, 8'h50, 0, 8'h5A);
    regop("R4 xor", 3'd4, 8'hFF, 0, 8'hA5);
    regop("R3 load user bits", 3'd1, 8'h50, 0, 8'h50);
    arith("R12 user bits kept by arith", 3'd0, 2'd0, 32'h0, 32'h0, 32'h0, 1, 8'h54);
  endtask

  task automatic t_clash();
    regop("R5 exception entry", 3'd0, 8'h00, 1, 8'hD4);
    regop("R5 exception beats load", 3'd1, 8'h00, 1, 8'h80);
    @(negedge clk_i);
    arith_valid_i = 1; arith_op_i = 3'd0; size_i = 2'd0; src_a_i = 32'hFF; src_b_i = 32'h01;
    ccr_op_i = 3'd1; ccr_imm_i = 8'h11;
    @(posedge clk_i); #1;
    arith_valid_i = 0; ccr_op_i = 0;
    chk("R12 register op wins over arith", 32'(ccr_o), 32'h11);
    @(posedge clk_i); #1;
    chk("R12 idle holds", 32'(ccr_o), 32'h11);
    chk("R2 mask follows bit 7", 32'(irq_mask_o), 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    #12 rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_byte_add();
    t_byte_sub();
    t_wide();
    t_cmp_neg();
    t_regops();
    t_clash();
    report();
  end
endmodule